// File: doc/BRIEF.md
# Hash Command Handshake Frontend

This block sits between a platform and a hash engine. The platform issues four commands: re-initialise, push an input word, pull an output word, and read a configuration word. Each push, pull or configuration read is a two-phase transfer. The platform raises its command line and keeps it high. The frontend answers with `ack`. A word moves on every rising edge where `ack` and the command are both high.

The frontend counts pushed words. Once a full block has arrived, it launches the core. While the core is working, every push sees wait states. When the core reports done, the digest words can be pulled one per transfer. A pull that arrives while no digest is available and the core is idle raises a sticky error flag. From then on, every pull returns an error word instead of a digest word.

The core in this project is a stand-in with a fixed latency. Its digest word k is the 32-bit wrapping sum of the block's words plus k. This lets the protocol be checked without a real hash.

Top module: `hash_cmd_frontend`

## Requirements
- R1: After `rst` (synchronous, active high), with no command raised, `ack`, `err` and `odata` are all zero.
- R2: `getconfig` is answered with `ack` in the same cycle. `odata` then carries the configuration word: bit 31 output streaming = 0, bit 30 input streaming = 0, bit 29 padding = 0, bits 23:16 = OUT_WORDS, bits 15:0 = IN_WORDS. With the defaults this is 32'h0008_0010.
- R3: Priority from highest to lowest is `rst`, `init`, `getconfig`, `fetch`, `load`. While `init` is high, `ack` is low. A lower-ranked command raised together with a higher one has no effect.
- R4: When the core is idle and `err` is low, `load` is acknowledged in the same cycle, one word per clock. The word is stored in the next slot of the block. The core starts when the IN_WORDS-th word is accepted.
- R5: From the edge that accepts the last word of a block until LATENCY+2 edges later, `load` and `fetch` are not acknowledged.
- R6: Once the digest is ready, `fetch` is acknowledged in the same cycle with digest word k on `odata`, for k = 0, 1, … OUT_WORDS-1 in order. Word k is the block's word sum plus k. After the last word has been taken, the digest is no longer available.
- R7: A `fetch` that finds no digest while the core is idle does not transfer. This includes a partly loaded block. It sets `err` on that edge. While `err` is high, `fetch` is acknowledged at once with error word 32'h0000_0001 (bit 0 = incomplete block), and `err` stays high.
- R8: While `err` is high, `load` is never acknowledged.
- R9: `init` clears `err`, the word count and any digest, and it aborts a running computation. After `init` a `fetch` finds no digest.
- R10: `ack` is low in any cycle where none of `load`, `fetch` or `getconfig` is high. This lets it drop in the cycle the command drops.
- R11: Accepting the first word of a new block discards any digest words not yet fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Re-initialise hash state and abort work |
| load | input | 1 | Request to push `idata` |
| fetch | input | 1 | Request to pull a digest or error word |
| getconfig | input | 1 | Request to read the configuration word |
| idata | input | 32 | Input word |
| ack | output | 1 | Transfer acknowledge, combinational from the command |
| err | output | 1 | Sticky error flag |
| odata | output | 32 | Output word, valid while `ack` answers `fetch` or `getconfig` |

## Verification
The bench goes after the edges of the busy window. A frontend that counted the window one cycle short would either take a word into a block still being hashed, or raise an error on a pull made just before the digest lands. It drains the digest past its last word. An index that failed to wrap would return stale data instead of the error word. It also overlaps commands and pulls `init` in the middle of a computation. Wrong ranking would show up as a stray `ack`. A digest that survived an abort would show up as a good word where the error word belongs. Finally, it starts a new block over an undrained digest, which must make the digest disappear.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    localparam int WORD_W = 32;

    // error word: bit 0 flags a pull with no complete block behind it
    localparam logic [WORD_W-1:0] ERR_WORD_SHORT = 32'h0000_0001;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_LOAD,
        CMD_FETCH,
        CMD_CFG
    } cmd_e;

    // streaming and padding capabilities are absent, so bits 31:29 are zero
    function automatic logic [WORD_W-1:0] make_cfg(input int out_words, input int in_words);
        return {3'b000, 5'b00000, 8'(out_words), 16'(in_words)};
    endfunction

endpackage

// File: rtl/hcf_block_buf.sv
module hcf_block_buf #(
    parameter int IN_WORDS = 16,
    parameter int IDX_W    = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [hcf_pkg::WORD_W-1:0]          wr_data,
    output logic [IN_WORDS*hcf_pkg::WORD_W-1:0] block
);
    localparam int W = hcf_pkg::WORD_W;

    for (genvar g = 0; g < IN_WORDS; g++) begin : g_slot
        logic [W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && wr_idx == IDX_W'(g)) slot_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q <= '0;
            else     slot_q <= slot_d;
        end

        assign block[g*W +: W] = slot_q;
    end

endmodule

// File: rtl/hcf_stub_core.sv
module hcf_stub_core #(
    parameter int IN_WORDS = 16,
    parameter int LATENCY  = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                abort,
    input  logic                                start,
    input  logic [IN_WORDS*hcf_pkg::WORD_W-1:0] block,
    output logic                                busy,
    output logic                                done,
    output logic [hcf_pkg::WORD_W-1:0]          result
);
    localparam int W     = hcf_pkg::WORD_W;
    localparam int TMR_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [TMR_W-1:0] tmr;
        logic [W-1:0]     acc;
    } core_t;

    core_t        st_d, st_q;
    logic [W-1:0] word_sum;

    always_comb begin
        word_sum = '0;
        for (int i = 0; i < IN_WORDS; i++) word_sum = word_sum + block[i*W +: W];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (abort) begin
            st_d.busy = 1'b0;
            st_d.tmr  = '0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.tmr  = TMR_W'(LATENCY);
            st_d.acc  = word_sum;
        end else if (st_q.busy) begin
            if (st_q.tmr == TMR_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr - TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.acc;

endmodule

// File: rtl/hash_cmd_frontend.sv
module hash_cmd_frontend #(
    parameter int IN_WORDS  = 16,
    parameter int OUT_WORDS = 8,
    parameter int LATENCY   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        load,
    input  logic        fetch,
    input  logic        getconfig,
    input  logic [31:0] idata,
    output logic        ack,
    output logic        err,
    output logic [31:0] odata
);
    import hcf_pkg::*;

    localparam int              IDX_W    = (IN_WORDS > 1) ? $clog2(IN_WORDS) : 1;
    localparam int              RD_W     = (OUT_WORDS > 1) ? $clog2(OUT_WORDS) : 1;
    localparam logic [WORD_W-1:0] CFG_WORD = make_cfg(OUT_WORDS, IN_WORDS);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
        logic [RD_W-1:0]  rd;
        logic             err;
        logic             ready;
        logic             launch;
    } ctl_t;

    ctl_t                        ctl_d, ctl_q;
    cmd_e                        cmd;
    logic                        wr_en;
    logic                        core_busy, core_done, busy_all;
    logic [WORD_W-1:0]           core_result;
    logic [IN_WORDS*WORD_W-1:0]  block;

    // ranking below init: configuration read, then pull, then push
    always_comb begin
        if (getconfig)  cmd = CMD_CFG;
        else if (fetch) cmd = CMD_FETCH;
        else if (load)  cmd = CMD_LOAD;
        else            cmd = CMD_NONE;
    end

    assign busy_all = ctl_q.launch | core_busy | core_done;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.launch = 1'b0;
        ack          = 1'b0;
        odata        = '0;
        wr_en        = 1'b0;
        if (init) begin
            ctl_d.cnt   = '0;
            ctl_d.rd    = '0;
            ctl_d.err   = 1'b0;
            ctl_d.ready = 1'b0;
        end else begin
            unique case (cmd)
                CMD_CFG: begin
                    ack   = 1'b1;
                    odata = CFG_WORD;
                end
                CMD_FETCH: begin
                    if (ctl_q.err) begin
                        ack   = 1'b1;
                        odata = ERR_WORD_SHORT;
                    end else if (ctl_q.ready) begin
                        ack   = 1'b1;
                        odata = core_result + WORD_W'(ctl_q.rd);
                        if (ctl_q.rd == RD_W'(OUT_WORDS - 1)) begin
                            ctl_d.rd    = '0;
                            ctl_d.ready = 1'b0;
                        end else begin
                            ctl_d.rd = ctl_q.rd + RD_W'(1);
                        end
                    end else if (!busy_all) begin
                        ctl_d.err = 1'b1;
                    end
                end
                CMD_LOAD: begin
                    if (!busy_all && !ctl_q.err) begin
                        ack         = 1'b1;
                        wr_en       = 1'b1;
                        ctl_d.ready = 1'b0;
                        if (ctl_q.cnt == IDX_W'(IN_WORDS - 1)) begin
                            ctl_d.cnt    = '0;
                            ctl_d.launch = 1'b1;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + IDX_W'(1);
                        end
                    end
                end
                default: ;
            endcase
            if (core_done) begin
                ctl_d.ready = 1'b1;
                ctl_d.rd    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign err = ctl_q.err;

    hcf_block_buf #(
        .IN_WORDS(IN_WORDS),
        .IDX_W   (IDX_W)
    ) i_buf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (ctl_q.cnt),
        .wr_data(idata),
        .block  (block)
    );

    hcf_stub_core #(
        .IN_WORDS(IN_WORDS),
        .LATENCY (LATENCY)
    ) i_core (
        .clk   (clk),
        .rst   (rst),
        .abort (init),
        .start (ctl_q.launch),
        .block (block),
        .busy  (core_busy),
        .done  (core_done),
        .result(core_result)
    );

endmodule

// File: rtl/hcf_checker.sv
module hcf_checker #(
    parameter int IN_WORDS  = 16,
    parameter int OUT_WORDS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        init,
    input logic        load,
    input logic        fetch,
    input logic        getconfig,
    input logic        ack,
    input logic        err,
    input logic [31:0] odata
);
    localparam logic [31:0] CFG_EXP = {8'h00, 8'(OUT_WORDS), 16'(IN_WORDS)};

    // R10
    ack_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (load || fetch || getconfig));

    // R3
    init_blocks_ack_chk: assert property (@(posedge clk) disable iff (rst)
        init |-> !ack);

    // R2
    cfg_word_chk: assert property (@(posedge clk) disable iff (rst)
        (getconfig && !init) |-> (ack && odata == CFG_EXP));

    // R9
    err_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        init |=> !err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !init) |=> err);

    // R7
    err_word_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch && err && !getconfig && !init) |-> (ack && odata == 32'h0000_0001));

    // R8
    no_load_in_err_chk: assert property (@(posedge clk) disable iff (rst)
        (load && err && !fetch && !getconfig) |-> !ack);

endmodule

bind hash_cmd_frontend hcf_checker #(
    .IN_WORDS (IN_WORDS),
    .OUT_WORDS(OUT_WORDS)
) i_hcf_checker (
    .clk      (clk),
    .rst      (rst),
    .init     (init),
    .load     (load),
    .fetch    (fetch),
    .getconfig(getconfig),
    .ack      (ack),
    .err      (err),
    .odata    (odata)
);

// File: tb/test_hash_cmd_frontend.sv
`timescale 1ns/1ps
module test_hash_cmd_frontend;
    localparam int IN_W  = 16;
    localparam int OUT_W = 8;
    localparam int LAT   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0, load = 1'b0, fetch = 1'b0, getconfig = 1'b0;
    logic [31:0] idata = '0;
    logic        ack, err;
    logic [31:0] odata;

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    string tag   = "R1";

    always #2.5 clk = ~clk;

    hash_cmd_frontend #(.IN_WORDS(IN_W), .OUT_WORDS(OUT_W), .LATENCY(LAT)) i_hash_cmd_frontend (
        .clk(clk), .rst(rst), .init(init), .load(load), .fetch(fetch),
        .getconfig(getconfig), .idata(idata), .ack(ack), .err(err), .odata(odata));

    // behavioural reference
    int          m_cnt, m_rd, m_left;
    bit          m_err, m_ready;
    logic [31:0] m_acc, m_pend, m_sum;
    logic [31:0] cfg_ref;
    assign cfg_ref = {8'h00, 8'(OUT_W), 16'(IN_W)};

    always @(posedge clk) begin
        bit busy;
        if (rst || init) begin
            m_cnt = 0; m_rd = 0; m_left = 0; m_err = 0; m_ready = 0; m_acc = 0;
        end else begin
            busy = (m_left > 0);
            if (getconfig) begin
            end else if (fetch) begin
                if (m_err) begin
                end else if (m_ready) begin
                    m_rd++;
                    if (m_rd == OUT_W) begin m_rd = 0; m_ready = 0; end
                end else if (!busy) m_err = 1;
            end else if (load && !busy && !m_err) begin
                m_ready = 0;
                m_acc   = m_acc + idata;
                m_cnt++;
                if (m_cnt == IN_W) begin
                    m_cnt = 0; m_pend = m_acc; m_acc = 0; m_left = LAT + 2;
                end
            end
            if (busy) begin
                m_left--;
                if (m_left == 0) begin m_ready = 1; m_rd = 0; m_sum = m_pend; end
            end
        end
    end

    always @(negedge clk) begin
        logic        e_ack;
        logic [31:0] e_od;
        if (!rst) begin
            e_ack = 0; e_od = 0;
            if (init) begin
            end else if (getconfig) begin e_ack = 1; e_od = cfg_ref; end
            else if (fetch) begin
                if (m_err) begin e_ack = 1; e_od = 32'h1; end
                else if (m_ready) begin e_ack = 1; e_od = m_sum + 32'(m_rd); end
            end else if (load) e_ack = (m_left == 0) && !m_err;
            total++;
            if (ack !== e_ack || err !== m_err || odata !== e_od) begin
                bad++;
                $display("FAIL %s cycle %0d: actual ack=%b err=%b odata=%h expected ack=%b err=%b odata=%h",
                         tag, cyc, ack, err, odata, e_ack, m_err, e_od);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic drive(input bit i, input bit l, input bit f, input bit g, input logic [31:0] d);
        init = i; load = l; fetch = f; getconfig = g; idata = d;
    endtask

    task automatic idle(input int n);
        drive(0, 0, 0, 0, '0);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic hold(input bit i, input bit l, input bit f, input bit g, input int n);
        drive(i, l, f, g, 32'hA5A5_0000);
        for (int k = 0; k < n; k++) step();
        drive(0, 0, 0, 0, '0);
    endtask

    // raise a two-phase command and keep it until the acknowledged edge
    task automatic xfer(input bit l, input bit f, input bit g, input logic [31:0] d,
                        output logic [31:0] got);
        bit seen = 0;
        drive(0, l, f, g, d);
        got = 'x;
        for (int k = 0; k < 64 && !seen; k++) begin
            @(negedge clk);
            seen = ack;
            if (ack) got = odata;
            @(posedge clk); #1;
        end
    endtask

    task automatic load_block(input logic [31:0] seed, output logic [31:0] sum);
        logic [31:0] tmp;
        sum = 0;
        for (int k = 0; k < IN_W; k++) begin
            xfer(1, 0, 0, seed * (k + 3) + 32'(k), tmp);
            sum = sum + seed * (k + 3) + 32'(k);
            if (k == 5) idle(1);
        end
        drive(0, 0, 0, 0, '0);
    endtask

    initial begin
        logic [31:0] got, sum;
        step(); step(); step();
        rst = 0;
        step();
        tag = "R1"; idle(2);
        @(negedge clk);
        chk("R1 ack", 32'(ack), 0); chk("R1 err", 32'(err), 0); chk("R1 odata", odata, 0);
        step();

        tag = "R2"; xfer(0, 0, 1, 0, got);
        chk("R2 config word", got, 32'h0008_0010);
        idle(1);

        tag = "R7"; xfer(0, 1, 0, 0, got);
        chk("R7 error word on empty pull", got, 32'h1);
        idle(1);
        @(negedge clk); chk("R7 err sticky", 32'(err), 1); step();

        tag = "R8"; hold(0, 1, 0, 0, 3);
        tag = "R3"; hold(0, 1, 1, 1, 2); hold(0, 1, 1, 0, 2);
        tag = "R9"; hold(1, 0, 0, 0, 1);
        @(negedge clk); chk("R9 err cleared", 32'(err), 0); step();

        tag = "R4"; load_block(32'h0101_0101, sum);
        tag = "R5"; hold(0, 1, 0, 0, LAT + 1);
        idle(2);
        tag = "R6";
        for (int k = 0; k < OUT_W; k++) begin
            xfer(0, 1, 0, 0, got);
            chk("R6 digest word", got, sum + 32'(k));
        end
        xfer(0, 1, 0, 0, got);
        chk("R6 drained digest gives error", got, 32'h1);
        tag = "R9"; hold(1, 0, 0, 0, 1);

        tag = "R7";
        for (int k = 0; k < 5; k++) xfer(1, 0, 0, 32'(k), got);
        xfer(0, 1, 0, 0, got);
        chk("R7 partial block", got, 32'h1);
        tag = "R9"; hold(1, 0, 0, 0, 1);

        tag = "R9"; load_block(32'h0BAD_F00D, sum);
        idle(2); hold(1, 0, 0, 0, 1); idle(LAT + 4);
        xfer(0, 1, 0, 0, got);
        chk("R9 aborted computation leaves no digest", got, 32'h1);
        hold(1, 0, 0, 0, 1);

        tag = "R11"; load_block(32'h1357_9BDF, sum);
        idle(LAT + 4);
        xfer(0, 1, 0, 0, got); chk("R11 first word", got, sum);
        xfer(0, 1, 0, 0, got); chk("R11 second word", got, sum + 1);
        xfer(1, 0, 0, 32'h77, got);
        xfer(0, 1, 0, 0, got);
        chk("R11 digest discarded", got, 32'h1);
        hold(1, 0, 0, 0, 1);

        tag = "R3"; hold(1, 1, 0, 0, 2); hold(1, 0, 1, 1, 1);
        tag = "R10"; idle(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule